// File: doc/BRIEF.md
# Serial Register Port

This block is a slave for a four-wire, chip-select framed serial link that reaches an 8-bit-address, 8-bit-data register file. It runs on the chip's system clock. The link pins (serial clock, active-low chip select, serial data in) are brought through two-flop synchronizers, and the block then looks for edges of the serial clock. A mode-strap input switches the port on. When the strap is low the port stays idle.

Each frame starts when chip select falls. The first bits are a 2-bit command and then the 8-bit address, most significant bit first, all taken on falling serial clock edges. A write then takes 8 data bits and gives the register file a single one-cycle write strobe. A read drives a 0 status bit on the first rising edge after the address, and then drives the 8 register bits on the rising edges that follow. The register side is a plain parallel bus with address, write data, write strobe and combinational read data. The serial clock must stay high and low for at least three system clock cycles each.

Top module: `ser_regport`

## Requirements
- R1: After reset, sdo, sdo_oe and reg_we are 0 and reg_addr is 0.
- R2: In each frame, the first two bits sampled on falling serial clock edges form the command. If the first command bit is 1 the frame is a read, and if it is 0 the frame is a write. The second command bit has no effect. The next 8 bits are the address, MSB first, and they appear on reg_addr.
- R3: A write frame takes 8 data bits, MSB first, after the address. reg_we pulses high for exactly one system cycle after the eighth data bit, with reg_addr and reg_wdata valid. Further serial clocks in the same frame do not produce another strobe.
- R4: On a read, the first rising edge after the address LSB drives a 0 on sdo. The next 8 rising edges drive reg_rdata, MSB first, as captured at that first rising edge. A read frame never raises reg_we.
- R5: sdo changes only in response to rising serial clock edges, so its value at a falling edge equals its value at the next rising edge.
- R6: While chip select is high, sdo and sdo_oe are 0. If chip select rises before the eighth data bit, the frame is dropped and no write takes place.
- R7: Every fall of chip select restarts the bit count, so a new frame decodes correctly after an aborted one.
- R8: While ser_mode is low, the port ignores all link activity: there is no strobe, and sdo and sdo_oe stay 0.
- R9: If the rise of chip select and the falling edge carrying the eighth data bit reach the synchronizers in the same cycle, the abort wins and no write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_mode | input | 1 | Strap: 1 enables the serial port |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master |
| sdo_oe | output | 1 | Output enable for sdo while the frame is active |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register read data for reg_addr |

## Verification
Two events can land in the same synchronized cycle: the falling serial clock edge that completes a write, and the rise of chip select that ends the frame. The bench drives both pins at the same instant on the eighth data bit. It judges the result by counting write strobes and by reading the target register back in a later frame, which must return its old value. A second bench case makes chip select rise one bit early, and a third completes the write normally, so the strobe is seen to depend only on which event wins.

// File: rtl/ser_regport.sv
module ser_regport #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_mode,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  localparam int HDR  = CW + AW;
  localparam int TOT  = HDR + DW;
  localparam int CNTW = $clog2(TOT + 2);
  localparam logic [CNTW-1:0] C_HDR  = CNTW'(HDR);
  localparam logic [CNTW-1:0] C_ALSB = CNTW'(HDR - 1);
  localparam logic [CNTW-1:0] C_DLSB = CNTW'(TOT - 1);
  localparam logic [CNTW-1:0] C_TOT  = CNTW'(TOT);
  localparam logic [CNTW-1:0] C_SAT  = CNTW'(TOT + 1);

  logic [1:0]      sclk_q, cs_q, sdi_q;
  logic            sclk_d;
  logic [CNTW-1:0] cnt;
  logic            is_rd;
  logic [AW-1:0]   addr_sh;
  logic [DW-1:0]   wd_sh;
  logic [DW-1:0]   rd_sh;

  wire act  = ser_mode & ~cs_q[1];
  wire fall = sclk_d & ~sclk_q[1];
  wire rise = ~sclk_d & sclk_q[1];
  wire bit_in = sdi_q[1];

  assign sdo_oe = act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      sdi_q  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[0], sclk};
      cs_q   <= {cs_q[0], cs_n};
      sdi_q  <= {sdi_q[0], sdi};
      sclk_d <= sclk_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      is_rd     <= 1'b0;
      addr_sh   <= '0;
      wd_sh     <= '0;
      rd_sh     <= '0;
      sdo       <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (!act) begin
        cnt   <= '0;
        is_rd <= 1'b0;
        sdo   <= 1'b0;
      end else begin
        if (fall) begin
          if (cnt != C_SAT) cnt <= cnt + 1'b1;
          if (cnt == '0) is_rd <= bit_in;
          if (cnt >= CNTW'(CW) && cnt < C_ALSB)
            addr_sh <= {addr_sh[AW-2:0], bit_in};
          if (cnt == C_ALSB)
            reg_addr <= {addr_sh[AW-2:0], bit_in};
          if (cnt >= C_HDR && cnt < C_DLSB)
            wd_sh <= {wd_sh[DW-2:0], bit_in};
          if (cnt == C_DLSB && !is_rd) begin
            reg_wdata <= {wd_sh[DW-2:0], bit_in};
            reg_we    <= 1'b1;
          end
        end
        if (rise) begin
          if (cnt == C_HDR) begin
            sdo   <= 1'b0;
            rd_sh <= reg_rdata;
          end else if (is_rd && cnt > C_HDR && cnt <= C_TOT) begin
            sdo   <= rd_sh[DW-1];
            rd_sh <= {rd_sh[DW-2:0], 1'b0};
          end else begin
            sdo <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ser_regport_chk.sv
module ser_regport_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ser_mode,
  input logic          cs_n,
  input logic          sdo,
  input logic          sdo_oe,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          is_rd
);
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R3

  AST_WE_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $stable(reg_addr)); // R3

  AST_NO_WE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !is_rd); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> (!sdo && !sdo_oe)); // R6

  AST_STRAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode && $past(!ser_mode) && $past(!ser_mode, 2)) |-> (!reg_we && !sdo && !sdo_oe)); // R8
endmodule

bind ser_regport ser_regport_chk #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .cs_n(cs_n), .sdo(sdo),
  .sdo_oe(sdo_oe), .reg_we(reg_we), .reg_addr(reg_addr), .is_rd(is_rd)
);

// File: tb/ser_regport_test.sv
module ser_regport_test;
  logic clk = 0, rst_n = 0, ser_mode = 1, sclk = 0, cs_n = 1, sdi = 0;
  logic sdo, sdo_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  int checks = 0, fails = 0, we_cnt = 0;
  logic [7:0] last_addr, last_data;

  always #2.5 clk = ~clk;

  ser_regport uut (.clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .sclk(sclk),
    .cs_n(cs_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) if (reg_we) begin
    we_cnt <= we_cnt + 1;
    last_addr <= reg_addr;
    last_data <= reg_wdata;
    mem[reg_addr] <= reg_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One serial clock cycle: rise, hold, fall, hold. Returns sdo before and after the fall.
  task automatic bit_cyc(input logic b, output logic sa, output logic sb);
    sdi = b; sclk = 1; wait_clk(6); sa = sdo;
    sclk = 0; wait_clk(6); sb = sdo;
  endtask

  // Runs ncyc serial cycles of {cmd, addr, data}; cs_n rises after.
  task automatic frame(input logic [1:0] cmd, input logic [7:0] a, input logic [7:0] d,
                       input int ncyc, output logic [8:0] rbits, output logic stable_ok);
    logic [17:0] v; logic sa, sb;
    v = {cmd, a, d}; rbits = '0; stable_ok = 1;
    cs_n = 0; wait_clk(6);
    for (int i = 0; i < ncyc; i++) begin
      bit_cyc(i < 18 ? v[17-i] : 1'b0, sa, sb);
      if (i >= 10 && i <= 18) begin
        rbits[18-i] = sb;
        if (sa !== sb) stable_ok = 0;
      end
    end
    wait_clk(6); cs_n = 1; wait_clk(8);
  endtask

  task automatic t_reset();
    chk("R1 sdo", sdo, 0); chk("R1 sdo_oe", sdo_oe, 0);
    chk("R1 reg_we", reg_we, 0); chk("R1 reg_addr", reg_addr, 0);
  endtask

  task automatic t_write(input logic [1:0] cmd, input logic [7:0] a, input logic [7:0] d, input int ncyc);
    logic [8:0] rb; logic ok; int w0;
    w0 = we_cnt;
    frame(cmd, a, d, ncyc, rb, ok);
    chk("R3 strobe count", we_cnt - w0, 1);
    chk("R2 address", last_addr, a);
    chk("R3 data", last_data, d);
  endtask

  task automatic t_read(input logic [1:0] cmd, input logic [7:0] a);
    logic [8:0] rb; logic ok; int w0;
    w0 = we_cnt;
    frame(cmd, a, 8'h00, 19, rb, ok);
    chk("R4 status bit", rb[8], 0);
    chk("R4 read data", rb[7:0], mem[a]);
    chk("R5 sdo stable across fall", ok, 1);
    chk("R4 no strobe on read", we_cnt - w0, 0);
    chk("R6 sdo idle", sdo, 0); chk("R6 sdo_oe idle", sdo_oe, 0);
  endtask

  task automatic t_abort();
    logic [8:0] rb; logic ok; int w0;
    w0 = we_cnt;
    frame(2'b00, 8'h40, 8'h99, 17, rb, ok);
    chk("R6 early abort no strobe", we_cnt - w0, 0);
    chk("R6 sdo with cs high", sdo, 0);
    t_read(2'b10, 8'h40);
  endtask

  task automatic t_restart();
    logic [8:0] rb; logic ok;
    frame(2'b00, 8'hFF, 8'hFF, 5, rb, ok);
    t_write(2'b00, 8'h22, 8'h5A, 18); // R7
    chk("R7 restart data", mem[8'h22], 8'h5A);
  endtask

  task automatic t_strap();
    logic [8:0] rb; logic ok; int w0;
    ser_mode = 0; wait_clk(4);
    w0 = we_cnt;
    cs_n = 0; wait_clk(8);
    chk("R8 sdo_oe with strap low", sdo_oe, 0);
    cs_n = 1; wait_clk(8);
    frame(2'b00, 8'h50, 8'h77, 18, rb, ok);
    chk("R8 no strobe", we_cnt - w0, 0);
    frame(2'b10, 8'h10, 8'h00, 19, rb, ok);
    chk("R8 sdo stays 0", rb, 0);
    ser_mode = 1; wait_clk(4);
    chk("R8 register untouched", mem[8'h50], 8'h50 ^ 8'hC3);
  endtask

  task automatic t_collide();
    logic [17:0] v; logic sa, sb; int w0;
    v = {2'b00, 8'h60, 8'hE7}; w0 = we_cnt;
    cs_n = 0; wait_clk(6);
    for (int i = 0; i < 17; i++) bit_cyc(v[17-i], sa, sb);
    sdi = v[0]; sclk = 1; wait_clk(6);
    sclk = 0; cs_n = 1; wait_clk(12);
    chk("R9 collision no strobe", we_cnt - w0, 0);
    t_read(2'b10, 8'h60);
    chk("R9 register kept", mem[8'h60], 8'h60 ^ 8'hC3);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hC3;
    wait_clk(3);
    t_reset();
    rst_n = 1; wait_clk(4);
    t_reset();
    t_write(2'b00, 8'hA5, 8'h3C, 18);
    t_write(2'b01, 8'h00, 8'hFF, 18); // R2 second command bit ignored
    t_write(2'b00, 8'h81, 8'h96, 22); // R3 extra clocks
    t_read(2'b10, 8'hA5);
    t_read(2'b11, 8'h81);
    t_read(2'b10, 8'h7E);
    t_abort();
    t_restart();
    t_strap();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #900us;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule